// File: doc/BRIEF.md
# Strobed Synchronous SRAM Array

This block models a single-clock synchronous static RAM with a 72-bit data bus. The bus carries eight 8-bit data lanes, and each lane has one parity bit. An active-low address strobe, qualified by an active-low chip enable, starts each access. The address is latched only when a new access starts. While the strobe stays high, later cycles keep working on that latched address.

Every sampled input is registered on the rising clock edge: address, write data, strobe, chip enable and byte-write enables. The output enable is the one exception and acts combinationally on the bus drivers. A cycle is a write when any byte-write enable is low. Only the selected lanes are updated, each together with its parity bit. Otherwise the cycle is a read, and the stored word is driven onto the bus after the registering edge, for as long as the output enable is low.

Top module: `ssram_core`

## Requirements
- R1: After reset the block is deselected and the bus is released. The held address is zero, so a strobe-high write right after reset lands at address 0.
- R2: An edge that samples the strobe low with chip enable high makes the next cycle a deselect. The bus is released and the held address is left unchanged.
- R3: An edge that samples both the strobe and chip enable low latches the external address. The cycle is a read when all byte-write enables are high.
- R4: An edge that samples the strobe high continues at the held address as a read or a write, and chip enable is ignored.
- R5: A cycle is a write when any byte-write enable is low. Lane k is data bits 8k+7..8k plus parity bit 64+k, and it is written only when enable bit k is low. All other lanes keep their contents.
- R6: In a read, the stored word appears on the bus once the edge that registered the read has passed, while the output enable is low.
- R7: The output enable is not clocked. Raising it releases the bus at once, and lowering it during a read drives the bus with no clock edge.
- R8: During a write cycle the bus is released whatever the output enable level.
- R9: The array is indexed by the low log2(DEPTH) address bits. Addresses that differ only above those bits reach the same word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| addr_i | input | ADDR_W (18) | Word address, latched on a qualified strobe |
| strobe_n_i | input | 1 | Active-low address strobe |
| cen_n_i | input | 1 | Active-low chip enable, qualifies the strobe |
| bwe_n_i | input | LANES (8) | Active-low byte-lane write enables |
| oe_n_i | input | 1 | Active-low output enable, combinational |
| dq_io | inout | LANES*(LANE_W+1) (72) | Data lanes in the low 64 bits, lane parity in the top 8 bits |

## Verification
The bench builds the block with DEPTH set to 16. This keeps the reference array small, and it puts aliasing within reach: an address with bit 16 set must reach the same word as its low-bit twin. The default width of 18 address bits is kept, so the latched address still travels at full width while only four bits select a word. The bench places pull-ups on the bus, so a released bus reads as all ones and can be told apart from driven read data.

// File: rtl/ssram_pkg.sv
package ssram_pkg;
    typedef enum logic [1:0] {
        CYC_IDLE  = 2'd0,
        CYC_READ  = 2'd1,
        CYC_WRITE = 2'd2
    } cyc_e;
endpackage

// File: rtl/ssram_ctrl.sv
module ssram_ctrl
    import ssram_pkg::*;
#(
    parameter int ADDR_W = 18,
    parameter int LANES  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic              strobe_n_i,
    input  logic              cen_n_i,
    input  logic [LANES-1:0]  bwe_n_i,
    output cyc_e              cyc_q_o,
    output logic [ADDR_W-1:0] acc_addr_o,
    output logic              acc_rd_o,
    output logic              acc_wr_o,
    output logic [LANES-1:0]  lane_we_o
);
    typedef struct packed {
        cyc_e              cyc;
        logic [ADDR_W-1:0] addr;
    } ctrl_st_t;

    ctrl_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (!strobe_n_i && cen_n_i) begin
            st_d.cyc = CYC_IDLE;
        end else begin
            if (!strobe_n_i) begin
                st_d.addr = addr_i;
            end
            st_d.cyc = (&bwe_n_i) ? CYC_READ : CYC_WRITE;
        end
        acc_addr_o = st_d.addr;
        acc_rd_o   = (st_d.cyc == CYC_READ);
        acc_wr_o   = (st_d.cyc == CYC_WRITE);
        lane_we_o  = acc_wr_o ? ~bwe_n_i : '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{cyc: CYC_IDLE, addr: '0};
        end else begin
            st_q <= st_d;
        end
    end

    assign cyc_q_o = st_q.cyc;

    // R2
    deselect_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!strobe_n_i && cen_n_i) |=> (st_q.cyc == CYC_IDLE) && $stable(st_q.addr));

    // R3
    addr_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!strobe_n_i && !cen_n_i) |=> (st_q.addr == $past(addr_i)));

    // R4
    strobe_high_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        strobe_n_i |=> $stable(st_q.addr) && (st_q.cyc != CYC_IDLE));
endmodule

// File: rtl/ssram_array.sv
module ssram_array #(
    parameter int ADDR_W = 18,
    parameter int DEPTH  = 1024,
    parameter int LANES  = 8,
    parameter int LANE_W = 8,
    localparam int IDX_W = $clog2(DEPTH),
    localparam int DAT_W = LANES * LANE_W,
    localparam int BUS_W = LANES * (LANE_W + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] acc_addr_i,
    input  logic              acc_rd_i,
    input  logic              acc_wr_i,
    input  logic [LANES-1:0]  lane_we_i,
    input  logic [BUS_W-1:0]  wdata_i,
    output logic [BUS_W-1:0]  rdata_o
);
    logic [IDX_W-1:0] idx;
    assign idx = acc_addr_i[IDX_W-1:0];

    for (genvar k = 0; k < LANES; k++) begin : g_lane
        logic [LANE_W:0] mem [DEPTH];
        logic [LANE_W:0] wlane;
        logic [LANE_W:0] rd_d, rd_q;

        assign wlane = {wdata_i[DAT_W + k], wdata_i[k*LANE_W +: LANE_W]};

        always_ff @(posedge clk) begin
            if (lane_we_i[k]) begin
                mem[idx] <= wlane;
            end
        end

        always_comb begin
            rd_d = rd_q;
            if (acc_rd_i) begin
                rd_d = mem[idx];
            end
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                rd_q <= '0;
            end else begin
                rd_q <= rd_d;
            end
        end

        assign rdata_o[k*LANE_W +: LANE_W] = rd_q[LANE_W-1:0];
        assign rdata_o[DAT_W + k]          = rd_q[LANE_W];
    end

    // R5
    lane_we_only_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !acc_wr_i |-> (lane_we_i == '0));

    // R5
    write_has_lane_chk: assert property (@(posedge clk) disable iff (!rst_n)
        acc_wr_i |-> (lane_we_i != '0) && !acc_rd_i);
endmodule

// File: rtl/ssram_core.sv
module ssram_core
    import ssram_pkg::*;
#(
    parameter int ADDR_W = 18,
    parameter int DEPTH  = 1024,
    parameter int LANES  = 8,
    parameter int LANE_W = 8,
    localparam int BUS_W = LANES * (LANE_W + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic              strobe_n_i,
    input  logic              cen_n_i,
    input  logic [LANES-1:0]  bwe_n_i,
    input  logic              oe_n_i,
    inout  wire  [BUS_W-1:0]  dq_io
);
    cyc_e              cyc_q;
    logic [ADDR_W-1:0] acc_addr;
    logic              acc_rd;
    logic              acc_wr;
    logic [LANES-1:0]  lane_we;
    logic [BUS_W-1:0]  rdata;
    logic              drive_en;

    ssram_ctrl #(.ADDR_W(ADDR_W), .LANES(LANES)) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .addr_i     (addr_i),
        .strobe_n_i (strobe_n_i),
        .cen_n_i    (cen_n_i),
        .bwe_n_i    (bwe_n_i),
        .cyc_q_o    (cyc_q),
        .acc_addr_o (acc_addr),
        .acc_rd_o   (acc_rd),
        .acc_wr_o   (acc_wr),
        .lane_we_o  (lane_we)
    );

    ssram_array #(.ADDR_W(ADDR_W), .DEPTH(DEPTH), .LANES(LANES), .LANE_W(LANE_W)) u_array (
        .clk        (clk),
        .rst_n      (rst_n),
        .acc_addr_i (acc_addr),
        .acc_rd_i   (acc_rd),
        .acc_wr_i   (acc_wr),
        .lane_we_i  (lane_we),
        .wdata_i    (dq_io),
        .rdata_o    (rdata)
    );

    assign drive_en = (cyc_q == CYC_READ) && !oe_n_i;
    assign dq_io    = drive_en ? rdata : 'z;

    // R8
    no_drive_in_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc_q == CYC_WRITE) |-> !drive_en);

    // R7
    oe_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        oe_n_i |-> !drive_en);
endmodule

// File: tb/tb_ssram_core.sv
module tb_ssram_core;
    localparam int CLK_PERIOD = 10;
    localparam int ADDR_W = 18;
    localparam int DEPTH  = 16;
    localparam int BUS_W  = 72;
    localparam logic [BUS_W-1:0] REL = '1;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [ADDR_W-1:0] addr = '0;
    logic              strobe_n = 1'b1;
    logic              cen_n = 1'b1;
    logic [7:0]        bwe_n = 8'hFF;
    logic              oe_n = 1'b1;
    logic [BUS_W-1:0]  tb_drv = '0;
    logic              tb_en = 1'b0;
    wire  [BUS_W-1:0]  dq;

    int checks = 0;
    int failures = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    assign dq = tb_en ? tb_drv : 'z;
    for (genvar b = 0; b < BUS_W; b++) begin : g_pu
        pullup pu (dq[b]);
    end

    ssram_core #(.ADDR_W(ADDR_W), .DEPTH(DEPTH)) dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .addr_i     (addr),
        .strobe_n_i (strobe_n),
        .cen_n_i    (cen_n),
        .bwe_n_i    (bwe_n),
        .oe_n_i     (oe_n),
        .dq_io      (dq)
    );

    typedef struct packed {
        logic              sn;
        logic              cn;
        logic [7:0]        bwe;
        logic              oe;
        logic [ADDR_W-1:0] a;
        logic [BUS_W-1:0]  d;
        logic [3:0]        req;
    } vec_t;

    localparam int NV = 14;
    localparam vec_t VECS [NV] = '{
        {1'b0, 1'b0, 8'h00, 1'b1, 18'h00002, 72'h5A_0123_4567_89AB_CDEF, 4'd5}, // R5 full write
        {1'b0, 1'b0, 8'hFF, 1'b0, 18'h00002, 72'h0,                      4'd3}, // R3 read latch
        {1'b1, 1'b1, 8'hFF, 1'b0, 18'h00005, 72'h0,                      4'd4}, // R4 held read, cen ignored
        {1'b0, 1'b0, 8'h00, 1'b1, 18'h00007, 72'hC3_FEDC_BA98_7654_3210, 4'd5}, // R5
        {1'b1, 1'b0, 8'hF0, 1'b0, 18'h00001, 72'h0F_AAAA_BBBB_CCCC_DDDD, 4'd8}, // R8 partial, oe low
        {1'b0, 1'b1, 8'hFF, 1'b0, 18'h00002, 72'h0,                      4'd2}, // R2 deselect
        {1'b1, 1'b0, 8'hFF, 1'b0, 18'h00002, 72'h0,                      4'd5}, // R5 merge at held 7
        {1'b0, 1'b0, 8'h00, 1'b1, 18'h10009, 72'h81_1357_9BDF_0246_8ACE, 4'd9}, // R9 alias write
        {1'b0, 1'b0, 8'hFF, 1'b0, 18'h00009, 72'h0,                      4'd9}, // R9 alias read
        {1'b0, 1'b0, 8'h7E, 1'b1, 18'h00002, 72'h3C_7777_6666_5555_4444, 4'd5}, // R5 lanes 0,7
        {1'b0, 1'b0, 8'hFF, 1'b1, 18'h00002, 72'h0,                      4'd7}, // R7 oe high
        {1'b1, 1'b0, 8'hFF, 1'b0, 18'h00000, 72'h0,                      4'd6}, // R6 read shown
        {1'b0, 1'b1, 8'hFF, 1'b0, 18'h00002, 72'h0,                      4'd2}, // R2
        {1'b1, 1'b1, 8'hFF, 1'b0, 18'h00003, 72'h0,                      4'd4}  // R4 held addr 2
    };

    logic [BUS_W-1:0]  ref_mem [DEPTH];
    logic [BUS_W-1:0]  ref_rd = '0;
    int                ref_mode = 0;
    logic [ADDR_W-1:0] ref_addr = '0;

    task automatic check(input string tag, input logic [BUS_W-1:0] exp);
        checks++;
        if (dq !== exp) begin
            failures++;
            $display("FAIL %s: bus=%h expected=%h", tag, dq, exp);
        end
    endtask

    function automatic logic [BUS_W-1:0] expect_bus();
        return (ref_mode == 1 && !oe_n) ? ref_rd : REL;
    endfunction

    task automatic model_edge(input vec_t v);
        int w;
        if (!v.sn && v.cn) begin
            ref_mode = 0;
        end else begin
            if (!v.sn) ref_addr = v.a;
            w = ref_addr[3:0];
            if (&v.bwe) begin
                ref_mode = 1;
                ref_rd = ref_mem[w];
            end else begin
                ref_mode = 2;
                for (int k = 0; k < 8; k++) begin
                    if (!v.bwe[k]) begin
                        ref_mem[w][k*8 +: 8] = v.d[k*8 +: 8];
                        ref_mem[w][64 + k]   = v.d[64 + k];
                    end
                end
            end
        end
    endtask

    task automatic apply(input vec_t v, input string tag);
        strobe_n = v.sn;
        cen_n    = v.cn;
        bwe_n    = v.bwe;
        oe_n     = v.oe;
        addr     = v.a;
        tb_drv   = v.d;
        tb_en    = !(&v.bwe);
        @(posedge clk);
        model_edge(v);
        #1;
        tb_en = 1'b0;
        @(negedge clk);
        check(tag, expect_bus());
    endtask

    initial begin
        #(CLK_PERIOD * 20000);
        failures++;
        checks++;
        $display("FAIL watchdog: bus=%h expected=finished run", dq);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        oe_n = 1'b0;
        repeat (3) @(negedge clk);
        check("R1 released in reset", REL);
        rst_n = 1'b1;
        oe_n = 1'b1;

        for (int i = 0; i < NV; i++) begin
            apply(VECS[i], $sformatf("R%0d vector %0d", VECS[i].req, i));
        end

        // R7: output enable acts without a clock edge
        apply({1'b0, 1'b0, 8'hFF, 1'b1, 18'h00007, 72'h0, 4'd7}, "R7 read with oe high");
        #2 oe_n = 1'b0;
        #1 check("R7 oe falls mid-cycle", ref_rd);
        oe_n = 1'b1;
        #1 check("R7 oe rises mid-cycle", REL);

        // R6: read right after write at the same address returns the new word
        apply({1'b0, 1'b0, 8'hFE, 1'b1, 18'h00007, 72'h00_0000_0000_0000_0055, 4'd5}, "R5 lane 0 write");
        apply({1'b1, 1'b0, 8'hFF, 1'b0, 18'h00000, 72'h0, 4'd6}, "R6 read after write");

        // R1: held address is zero after reset
        oe_n = 1'b1;
        @(negedge clk);
        rst_n = 1'b0;
        ref_mode = 0;
        ref_addr = '0;
        repeat (2) @(negedge clk);
        check("R1 bus after second reset", REL);
        rst_n = 1'b1;
        apply({1'b1, 1'b0, 8'h00, 1'b1, 18'h00005, 72'h42_0F0F_0F0F_F0F0_F0F0, 4'd1}, "R1 write at held addr");
        apply({1'b0, 1'b0, 8'hFF, 1'b0, 18'h00000, 72'h0, 4'd1}, "R1 read addr 0");

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule